// File: doc/BRIEF.md
# Packed Saturating DSP Arithmetic Unit

This unit performs one fixed-point arithmetic operation per clock for a signal-processing datapath. Two 32-bit sources, a 40-bit wide source and a 5-bit operation code come in together with a valid strobe. One clock edge later the unit presents a registered 32-bit result.

The operations are:
- a wrap-around 32-bit add;
- an overflow-clamping 32-bit add;
- a dual 16-bit add whose lanes do not interact;
- a clamp of a 40-bit signed value into the 32-bit signed range;
- a family of 16x16 multiplies with a 32-bit product. For each multiplier operand, the code picks the upper or lower halfword and a signed or unsigned reading.

An unknown code returns zero and raises an illegal-operation pulse. The unit keeps no flags and holds nothing beyond its output register. Decoding and register access are done by the surrounding pipeline.

Top module: `sat_dsp_alu`

## Requirements
- R1: While reset is held (active low), and after it is released, `result` is 0, and `resultValid` and `illegalOp` are 0.
- R2: An operation sampled with `opValid` high at a rising edge shows its result on `result`, with `resultValid` high, right after that edge. When `opValid` is low at an edge, `resultValid` goes low and `result` keeps its previous value.
- R3: Code 5'b00000 returns the sum of `srcA` and `srcB` modulo 2^32.
- R4: Code 5'b00001 is a clamping add. It treats a sum as overflowed only when both sources have equal bit 31 and the wrapped sum's bit 31 differs from theirs. Otherwise it returns the wrapped sum.
- R5: When the clamping add overflows, it returns 0x80000000 if both sources were negative and 0x7FFFFFFF if both were non-negative.
- R6: Code 5'b00010 adds bits 31:16 of the sources and, separately, bits 15:0. Each lane wraps modulo 2^16, and no carry passes from bit 15 into bit 16.
- R7: Code 5'b00011 reads `wideIn` as a 40-bit two's-complement value. It returns the value itself if it lies in [-2^31, 2^31-1], 0x7FFFFFFF if it lies above, and 0x80000000 if it lies below.
- R8: Codes with bit 4 set are multiplies. Bit 3 selects the upper halfword of `srcA` (1) or the lower one (0). Bit 2 makes the same choice for `srcB`. The result is the low 32 bits of the product.
- R9: In a multiply, bit 1 set reads the chosen `srcA` halfword as signed, and bit 0 set does the same for `srcB`. A clear bit reads that halfword as unsigned.
- R10: Codes 5'b00100 through 5'b01111 return 0 and drive `illegalOp` high for exactly the cycle of that result. `illegalOp` is 0 for every defined code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 5 | Operation code |
| srcA | input | 32 | First source operand |
| srcB | input | 32 | Second source operand |
| wideIn | input | 40 | 40-bit signed value for the clamp operation |
| result | output | 32 | Registered result |
| resultValid | output | 1 | Result register updated last edge |
| illegalOp | output | 1 | Last sampled code was undefined |

## Verification
The rarest cases are the clamp boundaries. The clamping add must overflow in both directions. It must also stay unclamped for mixed-sign sources and for same-sign sums that land exactly on the range limits. The 40-bit clamp needs values one step inside and one step outside both limits. Random operands almost never reach these points, so a directed sequence places them exactly. A random mix of all 32 codes then runs against a behavioural model that does integer arithmetic on every clock, and idle gaps in that mix exercise the hold behaviour.

// File: rtl/sda_pkg.sv
package sda_pkg;
  localparam int OP_W = 5;

  localparam logic [OP_W-1:0] OPC_ADD_WRAP = 5'b00000;
  localparam logic [OP_W-1:0] OPC_ADD_CLAMP = 5'b00001;
  localparam logic [OP_W-1:0] OPC_ADD_PAIR = 5'b00010;
  localparam logic [OP_W-1:0] OPC_CLAMP_WIDE = 5'b00011;
  localparam int MUL_FLAG_BIT = 4;

  typedef struct packed {
    logic load;
    logic illegal;
    logic addWrap;
    logic addClamp;
    logic addPair;
    logic clampWide;
    logic mul;
    logic selHiA;
    logic selHiB;
    logic sgnA;
    logic sgnB;
  } sdaCtrl_t;
endpackage

// File: rtl/sda_ctrl.sv
module sda_ctrl
  import sda_pkg::*;
(
  input  logic            opValid,
  input  logic [OP_W-1:0] opCode,
  output sdaCtrl_t        ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.load = opValid;
    if (opCode[MUL_FLAG_BIT]) begin
      ctrl.mul = 1'b1;
      ctrl.selHiA = opCode[3];
      ctrl.selHiB = opCode[2];
      ctrl.sgnA = opCode[1];
      ctrl.sgnB = opCode[0];
    end else begin
      case (opCode)
        OPC_ADD_WRAP:   ctrl.addWrap = 1'b1;
        OPC_ADD_CLAMP:  ctrl.addClamp = 1'b1;
        OPC_ADD_PAIR:   ctrl.addPair = 1'b1;
        OPC_CLAMP_WIDE: ctrl.clampWide = 1'b1;
        default:        ctrl.illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/sda_datapath.sv
module sda_datapath
  import sda_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WIDE_W = 40,
  parameter int LANES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  sdaCtrl_t          ctrl,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [WIDE_W-1:0] wideIn,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output logic              illegalOp
);
  localparam int LANE_W = DATA_W / LANES;
  localparam int HALF_W = DATA_W / 2;
  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MAX_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] sumWrap, sumClamp, sumPair, wideClamp, mulOut, nextVal;
  logic              addOvf, wideFits;

  assign sumWrap = srcA + srcB;

  // overflow only when same-sign sources produce opposite-sign sum
  assign addOvf = (srcA[MSB] == srcB[MSB]) && (sumWrap[MSB] != srcA[MSB]);
  assign sumClamp = addOvf ? (srcA[MSB] ? MAX_NEG : MAX_POS) : sumWrap;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign sumPair[g*LANE_W +: LANE_W] = srcA[g*LANE_W +: LANE_W] + srcB[g*LANE_W +: LANE_W];
  end

  logic [WIDE_W-DATA_W:0] wideTop;
  assign wideTop = wideIn[WIDE_W-1:DATA_W-1];
  assign wideFits = (&wideTop) | ~(|wideTop);
  assign wideClamp = wideFits ? wideIn[DATA_W-1:0] : (wideIn[WIDE_W-1] ? MAX_NEG : MAX_POS);

  logic [HALF_W-1:0] halfA, halfB;
  logic [HALF_W:0]   extA, extB;
  logic signed [DATA_W-1:0] mulA, mulB, mulProd;
  assign halfA = ctrl.selHiA ? srcA[DATA_W-1:HALF_W] : srcA[HALF_W-1:0];
  assign halfB = ctrl.selHiB ? srcB[DATA_W-1:HALF_W] : srcB[HALF_W-1:0];
  assign extA = {ctrl.sgnA & halfA[HALF_W-1], halfA};
  assign extB = {ctrl.sgnB & halfB[HALF_W-1], halfB};
  assign mulA = {{(DATA_W-HALF_W-1){extA[HALF_W]}}, extA};
  assign mulB = {{(DATA_W-HALF_W-1){extB[HALF_W]}}, extB};
  assign mulProd = mulA * mulB;
  assign mulOut = mulProd;

  always_comb begin
    nextVal = '0;
    if (ctrl.mul) nextVal = mulOut;
    else if (ctrl.addWrap) nextVal = sumWrap;
    else if (ctrl.addClamp) nextVal = sumClamp;
    else if (ctrl.addPair) nextVal = sumPair;
    else if (ctrl.clampWide) nextVal = wideClamp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
      resultValid <= 1'b0;
      illegalOp <= 1'b0;
    end else begin
      resultValid <= ctrl.load;
      illegalOp <= ctrl.load & ctrl.illegal;
      if (ctrl.load) result <= nextVal;
    end
  end

  assert_clamp_sign_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load && ctrl.addClamp && (srcA[MSB] == srcB[MSB]) |=> result[MSB] == $past(srcA[MSB]));

  assert_wide_sign_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load && ctrl.clampWide |=> result[MSB] == $past(wideIn[WIDE_W-1]));

  assert_illegal_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load && ctrl.illegal |=> (result == '0) && illegalOp);
endmodule

// File: rtl/sat_dsp_alu.sv
module sat_dsp_alu
  import sda_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WIDE_W = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [WIDE_W-1:0] wideIn,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output logic              illegalOp
);
  sdaCtrl_t ctrl;

  sda_ctrl ctrl_i (
    .opValid(opValid),
    .opCode(opCode),
    .ctrl(ctrl)
  );

  sda_datapath #(.DATA_W(DATA_W), .WIDE_W(WIDE_W), .LANES(2)) dp_i (
    .clk(clk),
    .rstN(rstN),
    .ctrl(ctrl),
    .srcA(srcA),
    .srcB(srcB),
    .wideIn(wideIn),
    .result(result),
    .resultValid(resultValid),
    .illegalOp(illegalOp)
  );

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !resultValid && $stable(result));

  assert_illegal_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> resultValid);

  assert_defined_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    opValid && (opCode[4] || opCode[3:2] == 2'b00) |=> !illegalOp);
endmodule

// File: tb/sat_dsp_alu_tb.sv
module sat_dsp_alu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [4:0]  opCode = '0;
  logic [31:0] srcA = '0, srcB = '0;
  logic [39:0] wideIn = '0;
  logic [31:0] result;
  logic        resultValid, illegalOp;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] lastExp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sat_dsp_alu dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .srcA(srcA), .srcB(srcB), .wideIn(wideIn),
    .result(result), .resultValid(resultValid), .illegalOp(illegalOp)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic longint clamp32(longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  function automatic logic [31:0] refCalc(logic [4:0] c, logic [31:0] a, logic [31:0] b, logic [39:0] w);
    longint sa, sb, xa, xb, r;
    sa = $signed(a);
    sb = $signed(b);
    if (c[4]) begin
      xa = c[3] ? longint'(a[31:16]) : longint'(a[15:0]);
      xb = c[2] ? longint'(b[31:16]) : longint'(b[15:0]);
      if (c[1] && xa >= 32768) xa = xa - 65536;
      if (c[0] && xb >= 32768) xb = xb - 65536;
      r = xa * xb;
      return r[31:0];
    end
    case (c)
      5'd0: return a + b;
      5'd1: begin r = clamp32(sa + sb); return r[31:0]; end
      5'd2: return {a[31:16] + b[31:16], a[15:0] + b[15:0]};
      5'd3: begin r = $signed(w); r = clamp32(r); return r[31:0]; end
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagOf(logic [4:0] c);
    if (c[4]) return (c[1] | c[0]) ? "R9" : "R8";
    case (c)
      5'd0: return "R3";
      5'd1: return "R4_R5";
      5'd2: return "R6";
      5'd3: return "R7";
      default: return "R10";
    endcase
  endfunction

  // apply at a falling edge, compare at the next falling edge
  task automatic runOp(logic [4:0] c, logic [31:0] a, logic [31:0] b, logic [39:0] w);
    logic [31:0] exp;
    string t;
    opValid = 1'b1; opCode = c; srcA = a; srcB = b; wideIn = w;
    exp = refCalc(c, a, b, w);
    t = tagOf(c);
    @(negedge clk);
    check({t, " result"}, result, exp);
    check("R2 valid", {31'b0, resultValid}, 32'd1);
    check("R10 illegalOp", {31'b0, illegalOp}, {31'b0, (c[4:2] == 3'b001 || c[4:2] == 3'b010 || c[4:2] == 3'b011)});
    lastExp = exp;
  endtask

  task automatic idleCycle();
    opValid = 1'b0; opCode = $urandom_range(0, 31); srcA = $urandom; srcB = $urandom;
    @(negedge clk);
    check("R2 hold result", result, lastExp);
    check("R2 idle valid", {31'b0, resultValid}, 32'd0);
    check("R10 idle illegalOp", {31'b0, illegalOp}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 result in reset", result, 32'h0);
    check("R1 valid in reset", {31'b0, resultValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 result after reset", result, 32'h0);
    check("R1 illegalOp after reset", {31'b0, illegalOp}, 32'd0);

    // R3 wrap add
    runOp(5'd0, 32'hFFFFFFFF, 32'h1, '0);
    runOp(5'd0, 32'd5, 32'd7, '0);
    runOp(5'd0, 32'h7FFFFFFF, 32'h1, '0);
    // R4 R5 clamping add
    runOp(5'd1, 32'h7FFFFFFF, 32'h80000000, '0);
    runOp(5'd1, 32'h40000000, 32'h40000000, '0);
    runOp(5'd1, 32'h80000000, 32'hFFFFFFFF, '0);
    runOp(5'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, '0);
    runOp(5'd1, 32'h7FFFFFFE, 32'h1, '0);
    runOp(5'd1, 32'hC0000000, 32'hC0000000, '0);
    // R6 lane add
    runOp(5'd2, 32'h0001FFFF, 32'h00010001, '0);
    runOp(5'd2, 32'hFFFF8000, 32'h00018000, '0);
    // R7 wide clamp
    runOp(5'd3, '0, '0, 40'h007FFFFFFF);
    runOp(5'd3, '0, '0, 40'h0080000000);
    runOp(5'd3, '0, '0, 40'hFF80000000);
    runOp(5'd3, '0, '0, 40'hFF7FFFFFFF);
    runOp(5'd3, '0, '0, 40'hFFFFFFFFFF);
    runOp(5'd3, '0, '0, 40'h8000000000);
    // R8 halfword selection
    for (int c = 16; c < 32; c += 4) runOp(c[4:0], 32'h00030002, 32'h00050007, '0);
    // R9 signedness
    for (int c = 16; c < 20; c++) runOp(c[4:0], 32'h1234FFFF, 32'hABCD0002, '0);
    for (int c = 16; c < 20; c++) runOp(c[4:0], 32'hFFFF8000, 32'h8000FFFF, '0);
    // R10 undefined codes
    runOp(5'd4, 32'h1, 32'h2, '0);
    runOp(5'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, '1);
    runOp(5'd0, 32'h10, 32'h20, '0);
    // R2 hold while idle
    idleCycle();
    idleCycle();

    // random mix with idle gaps
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb, rw;
      logic [7:0]  rt;
      ra = $urandom; rb = $urandom; rw = $urandom; rt = 8'($urandom);
      if ($urandom_range(0, 7) == 0) idleCycle();
      else runOp(5'($urandom_range(0, 31)), ra, rb, {rt, rw});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule